// File: doc/BRIEF.md
# Heater Power Command Shaper

This block produces the power command for an electric water heater stage once per control tick. It adds a feedforward base power, computed elsewhere from flow and inlet temperature, to a feedback trim built by integrating the outlet temperature error. The sum is then bounded by several safety limits. The trim ignores small errors inside a deadband and is held within a fixed range. A working setpoint walks toward the requested target in bounded steps. The command itself may move by at most a programmable step per tick. A cold-start cap and an outlet-untrusted cap lower the permitted maximum.

Sensor trust is held as a state: normal, degraded or inhibited. If the outlet or inlet sensor is untrusted, the block runs degraded. In that state the integration gain is reduced, and an untrusted inlet also swaps the base power for a fixed conservative value. If flow is untrusted, the block goes to inhibited in the same tick: the command drops to zero, the trim is cleared and a fault latch is set. Heating resumes only when flow is trusted again and an explicit re-validate pulse is given. After reset the block starts inhibited, so heating is off by default.

Top module: `heat_cmd_shaper`

## Requirements
- R1: On each tick that does not end in the inhibited state, the target is base + trim (trim is the integrator value held before this tick), saturated to the range 0 to the active cap. The active cap is P_MAX, lowered to COLD_CAP and/or OUT_CAP where those apply.
- R2: Each tick the command moves toward the target by at most `step_lim`. The cap is applied after this slew limit, so a lowered cap takes effect at once.
- R3: When |outlet error| <= DEADBAND, the integrator is left unchanged. Otherwise it adds the shifted error and is clamped to -I_LIM..+I_LIM.
- R4: The integrator increment is the error arithmetically shifted right by SH_BASE. SH_EXTRA is added to the shift in the degraded state, and SH_EXTRA is added again while cold start is asserted.
- R5: Each tick, the working setpoint moves toward `target_sp` by at most SP_STEP and stops exactly on the target. It is 0 after reset.
- R6: While `cold_start` is high, the command after the tick is no greater than COLD_CAP.
- R7: While `outlet_ok` is low, the command after the tick is no greater than OUT_CAP, and the state is degraded (unless inhibited).
- R8: While `inlet_ok` is low, `base_pwr` has no effect: BASE_SAFE is used in its place, and the state is degraded (unless inhibited).
- R9: A tick with `flow_ok` low moves the block to inhibited in that same tick. The command becomes 0 with no slew, the integrator is cleared, and `fault_latch` is set if the block was not already inhibited.
- R10: From inhibited, the block leaves only on a tick with both `flow_ok` and `revalidate` high. `fault_latch` clears at that point. Reset enters inhibited with `fault_latch` clear.
- R11: Without a tick, the command, working setpoint, state and fault latch hold their values whatever the other inputs do.
- R12: The `trust_state` encoding is 0 = normal, 1 = degraded, 2 = inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Control tick strobe; one update per high cycle |
| base_pwr | input | CW | Feedforward base power |
| err | input | EW | Signed outlet temperature error |
| target_sp | input | SPW | Requested setpoint |
| step_lim | input | CW | Maximum command change per tick |
| flow_ok | input | 1 | Flow reading trusted |
| outlet_ok | input | 1 | Outlet temperature trusted |
| inlet_ok | input | 1 | Inlet temperature trusted |
| cold_start | input | 1 | Cold-start mode |
| revalidate | input | 1 | Re-validation request to leave inhibited |
| cmd_out | output | CW | Bounded heater power command |
| work_sp | output | SPW | Ramped working setpoint |
| trust_state | output | 2 | Trust state (R12 encoding) |
| fault_latch | output | 1 | Flow-loss fault latched |

## Verification
The bench builds the block with P_MAX=200, COLD_CAP=120, OUT_CAP=80, BASE_SAFE=50, DEADBAND=3, I_LIM=40 and SP_STEP=5. With these values the integrator clamp is reached in four ticks and the full-scale cap in a single large step. Both caps fall below an ordinary base value, so the cap-after-slew drop shows at once. A negative trim can drive the raw sum below zero with small inputs. Gain shifts of 2, 3 and 4 give distinct increments (10, 5, 2 for an error of 40), so each mode's gain is visible directly in the command.

// File: rtl/heat_cmd_pkg.sv
package heat_cmd_pkg;

  typedef enum logic [1:0] {
    TS_NORMAL   = 2'd0,
    TS_DEGRADED = 2'd1,
    TS_INHIBIT  = 2'd2
  } trust_e;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int slew_int(input int cur, input int tgt, input int step);
    if (tgt > cur + step) return cur + step;
    if (tgt < cur - step) return cur - step;
    return tgt;
  endfunction

  function automatic int cap_int(input int pmax, input logic cold, input int cold_cap,
                                 input logic out_ok, input int out_cap);
    int c;
    c = pmax;
    if (cold && cold_cap < c) c = cold_cap;
    if (!out_ok && out_cap < c) c = out_cap;
    return c;
  endfunction

endpackage

// File: rtl/hcs_trust_fsm.sv
module hcs_trust_fsm
  import heat_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   flow_ok,
  input  logic   outlet_ok,
  input  logic   inlet_ok,
  input  logic   revalidate,
  output trust_e state_q,
  output trust_e state_d,
  output logic   fault_q,
  output logic   ev_trip,
  output logic   ev_release
);

  trust_e run_state;

  always_comb begin
    run_state = (outlet_ok && inlet_ok) ? TS_NORMAL : TS_DEGRADED;
    state_d   = state_q;
    if (tick) begin
      if (state_q == TS_INHIBIT) begin
        if (flow_ok && revalidate) state_d = run_state;
      end else begin
        state_d = flow_ok ? run_state : TS_INHIBIT;
      end
    end
  end

  assign ev_trip    = (state_q != TS_INHIBIT) && (state_d == TS_INHIBIT);
  assign ev_release = (state_q == TS_INHIBIT) && (state_d != TS_INHIBIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_INHIBIT;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_trip) fault_q <= 1'b1;
      else if (ev_release) fault_q <= 1'b0;
    end
  end

endmodule

// File: rtl/hcs_trim_integ.sv
module hcs_trim_integ
  import heat_cmd_pkg::*;
#(
  parameter int EW       = 12,
  parameter int IW       = 12,
  parameter int DEADBAND = 4,
  parameter int I_LIM    = 256,
  parameter int SH_BASE  = 2,
  parameter int SH_EXTRA = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic signed [EW-1:0] err,
  input  logic                 degraded,
  input  logic                 cold,
  input  logic                 clear,
  output logic signed [IW-1:0] integ_q,
  output logic                 db_hold
);

  int err_i;
  int mag_i;
  int sh_i;
  int sum_i;

  always_comb begin
    err_i   = int'(err);
    mag_i   = (err_i < 0) ? -err_i : err_i;
    db_hold = (mag_i <= DEADBAND);
    sh_i    = SH_BASE + (degraded ? SH_EXTRA : 0) + (cold ? SH_EXTRA : 0);
    sum_i   = int'(integ_q) + (err_i >>> sh_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
    end else if (tick) begin
      if (clear) integ_q <= '0;
      else if (!db_hold) integ_q <= IW'(clamp_int(sum_i, -I_LIM, I_LIM));
    end
  end

endmodule

// File: rtl/hcs_sp_ramp.sv
module hcs_sp_ramp
  import heat_cmd_pkg::*;
#(
  parameter int SPW     = 10,
  parameter int SP_STEP = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [SPW-1:0] target,
  output logic [SPW-1:0] work_sp
);

  int next_i;

  always_comb begin
    next_i = slew_int(int'(work_sp), int'(target), SP_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) work_sp <= '0;
    else if (tick) work_sp <= SPW'(next_i);
  end

endmodule

// File: rtl/heat_cmd_shaper.sv
module heat_cmd_shaper
  import heat_cmd_pkg::*;
#(
  parameter int CW        = 10,
  parameter int EW        = 12,
  parameter int SPW       = 10,
  parameter int IW        = 12,
  parameter int P_MAX     = 1000,
  parameter int COLD_CAP  = 600,
  parameter int OUT_CAP   = 400,
  parameter int BASE_SAFE = 300,
  parameter int DEADBAND  = 4,
  parameter int I_LIM     = 256,
  parameter int SH_BASE   = 2,
  parameter int SH_EXTRA  = 1,
  parameter int SP_STEP   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [CW-1:0]        base_pwr,
  input  logic signed [EW-1:0] err,
  input  logic [SPW-1:0]       target_sp,
  input  logic [CW-1:0]        step_lim,
  input  logic                 flow_ok,
  input  logic                 outlet_ok,
  input  logic                 inlet_ok,
  input  logic                 cold_start,
  input  logic                 revalidate,
  output logic [CW-1:0]        cmd_out,
  output logic [SPW-1:0]       work_sp,
  output logic [1:0]           trust_state,
  output logic                 fault_latch
);

  localparam int CMD_CEIL = (1 << CW) - 1;
  localparam int P_TOP    = (P_MAX < CMD_CEIL) ? P_MAX : CMD_CEIL;

  trust_e state_q, state_d;
  logic   ev_trip, ev_release;
  logic   inhibit_d, degraded_d;
  logic   db_hold;
  logic   ev_cap_cut;
  logic signed [IW-1:0] integ_q;

  int base_i, cap_i, raw_i, tgt_i, slew_i, next_i;

  hcs_trust_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .flow_ok(flow_ok), .outlet_ok(outlet_ok), .inlet_ok(inlet_ok),
    .revalidate(revalidate),
    .state_q(state_q), .state_d(state_d), .fault_q(fault_latch),
    .ev_trip(ev_trip), .ev_release(ev_release)
  );

  assign inhibit_d  = (state_d == TS_INHIBIT);
  assign degraded_d = (state_d == TS_DEGRADED);

  hcs_trim_integ #(
    .EW(EW), .IW(IW), .DEADBAND(DEADBAND), .I_LIM(I_LIM),
    .SH_BASE(SH_BASE), .SH_EXTRA(SH_EXTRA)
  ) u_trim (
    .clk(clk), .rst_n(rst_n), .tick(tick), .err(err),
    .degraded(degraded_d), .cold(cold_start), .clear(inhibit_d),
    .integ_q(integ_q), .db_hold(db_hold)
  );

  hcs_sp_ramp #(.SPW(SPW), .SP_STEP(SP_STEP)) u_ramp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .target(target_sp), .work_sp(work_sp)
  );

  always_comb begin
    base_i = inlet_ok ? int'(base_pwr) : BASE_SAFE;
    cap_i  = cap_int(P_TOP, cold_start, COLD_CAP, outlet_ok, OUT_CAP);
    raw_i  = base_i + int'(integ_q);
    tgt_i  = clamp_int(raw_i, 0, cap_i);
    slew_i = slew_int(int'(cmd_out), tgt_i, int'(step_lim));
    next_i = (slew_i > cap_i) ? cap_i : slew_i;
  end

  assign ev_cap_cut = (slew_i > cap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_out <= '0;
    else if (tick) cmd_out <= inhibit_d ? '0 : CW'(next_i);
  end

  assign trust_state = state_q;

endmodule

// File: rtl/hcs_chk.sv
module hcs_chk #(
  parameter int CW       = 10,
  parameter int SPW      = 10,
  parameter int IW       = 12,
  parameter int P_MAX    = 1000,
  parameter int COLD_CAP = 600,
  parameter int OUT_CAP  = 400,
  parameter int I_LIM    = 256,
  parameter int SP_STEP  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 flow_ok,
  input logic                 outlet_ok,
  input logic                 cold_start,
  input logic                 revalidate,
  input logic [CW-1:0]        step_lim,
  input logic [CW-1:0]        cmd_out,
  input logic [SPW-1:0]       work_sp,
  input logic [1:0]           trust_state,
  input logic                 fault_latch,
  input logic signed [IW-1:0] integ_q,
  input logic                 db_hold,
  input logic                 ev_cap_cut
);

  AST_CMD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cmd_out) <= P_MAX); // R1

  AST_SLEW_UP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> int'(cmd_out) <= int'($past(cmd_out)) + int'($past(step_lim))); // R2

  AST_CAP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ev_cap_cut |=> int'(cmd_out) < int'($past(cmd_out)) + int'($past(step_lim)) + 1); // R2

  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tick && db_hold && flow_ok && trust_state != 2'd2 |=> integ_q == $past(integ_q)); // R3

  AST_INTEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(integ_q) <= I_LIM && int'(integ_q) >= -I_LIM); // R3

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((int'(work_sp) - int'($past(work_sp)) <= SP_STEP) &&
              (int'($past(work_sp)) - int'(work_sp) <= SP_STEP))); // R5

  AST_COLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cold_start |=> int'(cmd_out) <= COLD_CAP); // R6

  AST_OUTLET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !outlet_ok |=> int'(cmd_out) <= OUT_CAP); // R7

  AST_FLOW_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !flow_ok |=> trust_state == 2'd2 && cmd_out == '0 && integ_q == '0); // R9

  AST_INHIBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trust_state == 2'd2 |-> cmd_out == '0); // R9

  AST_STAY_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    trust_state == 2'd2 && !(tick && flow_ok && revalidate) |=> trust_state == 2'd2); // R10

  AST_FAULT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latch |-> trust_state == 2'd2); // R10

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cmd_out) && $stable(work_sp) && $stable(trust_state) && $stable(fault_latch)); // R11

  AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    trust_state != 2'd3); // R12

endmodule

bind heat_cmd_shaper hcs_chk #(
  .CW(CW), .SPW(SPW), .IW(IW), .P_MAX(P_MAX), .COLD_CAP(COLD_CAP),
  .OUT_CAP(OUT_CAP), .I_LIM(I_LIM), .SP_STEP(SP_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .flow_ok(flow_ok),
  .outlet_ok(outlet_ok), .cold_start(cold_start), .revalidate(revalidate),
  .step_lim(step_lim), .cmd_out(cmd_out), .work_sp(work_sp),
  .trust_state(trust_state), .fault_latch(fault_latch),
  .integ_q(integ_q), .db_hold(db_hold), .ev_cap_cut(ev_cap_cut)
);

// File: tb/tb_heat_cmd_shaper.sv
`timescale 1ns/1ps
module tb_heat_cmd_shaper;

  localparam int CW = 10, EW = 12, SPW = 10, IW = 12;
  localparam int PMX = 200, CCAP = 120, OCAP = 80, SAFE = 50;
  localparam int DB = 3, ILIM = 40, SHB = 2, SHX = 1, SPS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [CW-1:0] base_pwr = '0;
  logic signed [EW-1:0] err = '0;
  logic [SPW-1:0] target_sp = '0;
  logic [CW-1:0] step_lim = '0;
  logic flow_ok = 1'b0, outlet_ok = 1'b1, inlet_ok = 1'b1;
  logic cold_start = 1'b0, revalidate = 1'b0;
  logic [CW-1:0] cmd_out;
  logic [SPW-1:0] work_sp;
  logic [1:0] trust_state;
  logic fault_latch;

  heat_cmd_shaper #(
    .CW(CW), .EW(EW), .SPW(SPW), .IW(IW), .P_MAX(PMX), .COLD_CAP(CCAP),
    .OUT_CAP(OCAP), .BASE_SAFE(SAFE), .DEADBAND(DB), .I_LIM(ILIM),
    .SH_BASE(SHB), .SH_EXTRA(SHX), .SP_STEP(SPS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .base_pwr(base_pwr), .err(err),
    .target_sp(target_sp), .step_lim(step_lim), .flow_ok(flow_ok),
    .outlet_ok(outlet_ok), .inlet_ok(inlet_ok), .cold_start(cold_start),
    .revalidate(revalidate), .cmd_out(cmd_out), .work_sp(work_sp),
    .trust_state(trust_state), .fault_latch(fault_latch)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // independent expectation state
  int e_cmd = 0, e_int = 0, e_state = 2, e_sp = 0;
  bit e_fault = 1'b0;

  function automatic int lo_of(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic expect_field(input string req, input string name, input int got, input int want);
    if (got != want) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, got, want);
    end
  endtask

  task automatic compare(input string req);
    vectors++;
    expect_field(req, "cmd_out", int'(cmd_out), e_cmd);
    expect_field(req, "work_sp", int'(work_sp), e_sp);
    expect_field(req, "trust_state", int'(trust_state), e_state);
    expect_field(req, "fault_latch", int'(fault_latch), int'(e_fault));
  endtask

  // predict one tick from the requirement text
  task automatic predict(input int b, input int e, input int tsp, input int stp,
                         input bit fl, input bit ol, input bit il, input bit cs, input bit rv);
    int nxt, limit, want, shift, mag, acc;
    bit healthy;
    healthy = ol && il;
    if (e_state == 2) nxt = (fl && rv) ? (healthy ? 0 : 1) : 2;  // R10
    else nxt = !fl ? 2 : (healthy ? 0 : 1);                      // R7 R8 R9
    if (nxt == 2 && e_state != 2) e_fault = 1'b1;
    if (nxt != 2 && e_state == 2) e_fault = 1'b0;
    if (nxt == 2) begin
      e_cmd = 0;
    end else begin
      limit = PMX;
      if (cs) limit = lo_of(limit, CCAP);
      if (!ol) limit = lo_of(limit, OCAP);
      want = (il ? b : SAFE) + e_int;
      if (want < 0) want = 0;
      if (want > limit) want = limit;
      if (want - e_cmd > stp) want = e_cmd + stp;
      if (e_cmd - want > stp) want = e_cmd - stp;
      e_cmd = lo_of(want, limit);
    end
    if (nxt == 2) begin
      e_int = 0;
    end else begin
      mag = (e < 0) ? -e : e;
      if (mag > DB) begin
        shift = SHB + ((nxt == 1) ? SHX : 0) + (cs ? SHX : 0);
        acc = e_int + (e >>> shift);
        if (acc > ILIM) acc = ILIM;
        if (acc < -ILIM) acc = -ILIM;
        e_int = acc;
      end
    end
    if (tsp > e_sp) e_sp = lo_of(e_sp + SPS, tsp);
    else if (tsp < e_sp) e_sp = (e_sp - SPS > tsp) ? e_sp - SPS : tsp;
    e_state = nxt;
  endtask

  task automatic apply(input string req, input int b, input int e, input int tsp, input int stp,
                       input bit fl, input bit ol, input bit il, input bit cs, input bit rv);
    @(negedge clk);
    base_pwr = CW'(b); err = EW'(e); target_sp = SPW'(tsp); step_lim = CW'(stp);
    flow_ok = fl; outlet_ok = ol; inlet_ok = il; cold_start = cs; revalidate = rv;
    tick = 1'b1;
    predict(b, e, tsp, stp, fl, ol, il, cs, rv);
    @(negedge clk);
    tick = 1'b0; revalidate = 1'b0;
    compare(req);
  endtask

  task automatic t_reset();
    compare("R10_reset");
    compare("R12_reset_code");
  endtask

  task automatic t_revalidate();
    apply("R10_no_pulse", 150, 0, 0, 20, 1, 1, 1, 0, 0);
    apply("R10_pulse_no_flow", 150, 0, 0, 20, 0, 1, 1, 0, 1);
    apply("R10_release", 150, 0, 0, 20, 1, 1, 1, 0, 1);
    expect_field("R2_first_step", "cmd_out", int'(cmd_out), 20);
  endtask

  task automatic t_slew();
    for (int k = 0; k < 8; k++) apply("R2_slew_up", 150, 0, 0, 20, 1, 1, 1, 0, 0);
    expect_field("R1_base_reached", "cmd_out", int'(cmd_out), 150);
    apply("R2_slew_down", 90, 0, 0, 20, 1, 1, 1, 0, 0);
    expect_field("R2_down_step", "cmd_out", int'(cmd_out), 130);
    for (int k = 0; k < 4; k++) apply("R2_settle", 150, 0, 0, 20, 1, 1, 1, 0, 0);
  endtask

  task automatic t_deadband();
    apply("R3_db_pos", 150, 3, 0, 20, 1, 1, 1, 0, 0);
    apply("R3_db_neg", 150, -3, 0, 20, 1, 1, 1, 0, 0);
    apply("R3_db_zero", 150, 0, 0, 20, 1, 1, 1, 0, 0);
    expect_field("R3_db_hold", "cmd_out", int'(cmd_out), 150);
  endtask

  task automatic t_gain_clamp();
    apply("R4_gain_normal", 150, 40, 0, 20, 1, 1, 1, 0, 0);
    apply("R4_gain_normal_use", 150, 0, 0, 20, 1, 1, 1, 0, 0);
    expect_field("R4_shift2", "cmd_out", int'(cmd_out), 160);
    for (int k = 0; k < 6; k++) apply("R3_clamp_up", 150, 40, 0, 20, 1, 1, 1, 0, 0);
    expect_field("R3_clamp_top", "cmd_out", int'(cmd_out), 190);
  endtask

  task automatic t_saturate();
    apply("R1_sat_high", 400, 0, 0, 1023, 1, 1, 1, 0, 0);
    expect_field("R1_pmax", "cmd_out", int'(cmd_out), PMX);
    for (int k = 0; k < 8; k++) apply("R1_sat_low", 10, -200, 0, 1023, 1, 1, 1, 0, 0);
    expect_field("R1_zero_floor", "cmd_out", int'(cmd_out), 0);
    for (int k = 0; k < 8; k++) apply("R3_unwind", 100, 100, 0, 1023, 1, 1, 1, 0, 0);
  endtask

  task automatic t_cold();
    apply("R6_cold_cap", 190, 0, 0, 5, 1, 1, 1, 1, 0);
    for (int k = 0; k < 3; k++) apply("R4_cold_shift", 60, -40, 0, 5, 1, 1, 1, 1, 0);
    for (int k = 0; k < 3; k++) apply("R6_cold_release", 190, 0, 0, 30, 1, 1, 1, 0, 0);
  endtask

  task automatic t_outlet();
    apply("R7_outlet_cap", 190, 40, 0, 10, 1, 0, 1, 0, 0);
    expect_field("R7_degraded", "trust_state", int'(trust_state), 1);
    for (int k = 0; k < 3; k++) apply("R4_degraded_shift", 20, -40, 0, 10, 1, 0, 1, 1, 0);
    for (int k = 0; k < 3; k++) apply("R7_recover", 150, 0, 0, 60, 1, 1, 1, 0, 0);
  endtask

  task automatic t_inlet();
    apply("R8_inlet_base0", 0, 0, 0, 1023, 1, 1, 0, 0, 0);
    apply("R8_inlet_base500", 500, 0, 0, 1023, 1, 1, 0, 0, 0);
    apply("R8_inlet_base900", 900, 0, 0, 1023, 1, 1, 0, 0, 0);
    expect_field("R8_degraded", "trust_state", int'(trust_state), 1);
  endtask

  task automatic t_flow_loss();
    apply("R8_run", 150, 0, 0, 1023, 1, 1, 1, 0, 0);
    apply("R9_flow_lost", 150, 0, 0, 1, 0, 1, 1, 0, 0);
    expect_field("R9_zero", "cmd_out", int'(cmd_out), 0);
    expect_field("R9_fault", "fault_latch", int'(fault_latch), 1);
    apply("R10_still_inhibit", 150, 0, 0, 1023, 1, 1, 1, 0, 0);
    apply("R10_revalidated", 150, 0, 0, 1023, 1, 1, 1, 0, 1);
    expect_field("R10_fault_clear", "fault_latch", int'(fault_latch), 0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    base_pwr = 10'd0; err = -12'sd500; target_sp = 10'd900; step_lim = 10'd1023;
    flow_ok = 1'b0; outlet_ok = 1'b0; inlet_ok = 1'b0; cold_start = 1'b1; revalidate = 1'b1;
    repeat (5) @(negedge clk);
    revalidate = 1'b0;
    compare("R11_no_tick_hold");
  endtask

  task automatic t_ramp();
    for (int k = 0; k < 6; k++) apply("R5_ramp_up", 150, 0, 23, 1023, 1, 1, 1, 0, 0);
    expect_field("R5_on_target", "work_sp", int'(work_sp), 23);
    apply("R5_ramp_down", 150, 0, 3, 1023, 1, 1, 1, 0, 0);
    expect_field("R5_down_step", "work_sp", int'(work_sp), 18);
    for (int k = 0; k < 4; k++) apply("R5_ramp_down", 150, 0, 3, 1023, 1, 1, 1, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog all-requirements actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_revalidate();
    t_slew();
    t_deadband();
    t_gain_clamp();
    t_saturate();
    t_cold();
    t_outlet();
    t_inlet();
    t_flow_loss();
    t_hold();
    t_ramp();
    finish_run();
  end

endmodule